// File: doc/BRIEF.md
# Multiply-Accumulate Filter Coprocessor

This block is a small filter engine that sits beside a host processor and computes one output of a finite-impulse-response filter per run. It holds its own coefficient memory and its own delay-line memory. The host fills both memories, picks a tap count and a fixed-point output format, stages the newest input sample and writes a start command. The engine then moves the staged sample into the head of the delay line and pushes every older sample one place down. In the same pass it forms the sum of products with one signed 32x32 multiply-accumulate per clock into a 72-bit accumulator. At the end it scales and saturates the sum into a 32-bit result.

During a run the host is fenced out of everything except the command and status registers. Writes to memories or configuration are dropped and recorded in a sticky error bit, and reads of them return zero. Completion is signalled by a done flag, a level interrupt gated by an enable bit, and a one-cycle pulse meant to start a DMA transfer, also gated by an enable bit.

Register map (8-bit word address): 0x00 command, 0x01 status, 0x02 configuration, 0x03 staged sample, 0x04 result, 0x40+i coefficient i, 0x80+i delay-line word i.

Top module: `macflt_core`

## Requirements
- R1: After reset, status (0x01) reads 0, result (0x04) reads 0, configuration (0x02) reads 0x00000001 (one tap, format 0, both enables off), and irq and dma_req are low.
- R2: Writing 1 in bit 0 of the command register (0x00) while idle starts a run. Busy (status bit 0) stays high for exactly N+2 cycles, where N is the tap count. The end-of-run outputs (done, irq, dma_req, result) change on the (N+2)-th rising edge after the edge that took the command.
- R3: A run with N taps first sets D[i] to old D[i-1] for 1 <= i < N and D[0] to the staged sample (0x03), leaving D[N..] untouched. It then accumulates the signed products C[i]*D[i] for i < N with the updated values, where C[i] is at 0x40+i and D[i] is at 0x80+i.
- R4: Configuration bits [9:8] choose the arithmetic right shift applied to the accumulator before the result is formed: code 0 shifts by 0, code 1 by 15, code 2 by 23, code 3 by 31.
- R5: A shifted sum above 0x7FFFFFFF gives 0x7FFFFFFF, and one below -2^31 gives 0x80000000. Status bit 3 is 1 exactly when the last run clipped.
- R6: While busy, host writes to configuration, staged sample, coefficient or delay-line locations leave them unchanged and set status bit 2. That bit stays set until the host writes 1 to it.
- R7: While busy, host reads of configuration, staged sample, result, coefficient and delay-line locations return 0, while status still reports busy and error.
- R8: A start command written while busy is ignored; the run in progress keeps its N+2 cycle length.
- R9: Status bit 1 (done) is set at the end of a run, is cleared by writing 1 to it or by a new start, and irq is high while done is set and configuration bit 12 is 1.
- R10: When configuration bit 13 is 1, dma_req is high for exactly one cycle at the end of a run; when it is 0, dma_req stays low.
- R11: The tap count in configuration bits [6:0] is clamped on write: 0 is stored as 1 and values above 64 are stored as 64, and read-back shows the stored value.
- R12: Read data for a host_rd taken at a rising edge is on host_rdata after that edge and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one word per cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| irq | output | 1 | Completion interrupt level |
| dma_req | output | 1 | One-cycle end-of-run transfer request |

## Verification
Results of a run are due on the (N+2)-th rising edge after the start edge. The bench counts edges from the start and samples dma_req and irq at the falling edge just before and just after that one, so an early or late finish is caught. Read data is due one edge after the read strobe, so each read task samples at the next falling edge. A run with extra host traffic while busy is timed with a free cycle counter, to show that the blocked accesses and a repeated start do not change the run length.

// File: rtl/macflt_pkg.sv
package macflt_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_PRIME  = 2'd1,
    ENG_MAC    = 2'd2,
    ENG_FINISH = 2'd3
  } eng_state_e;

  typedef enum logic [1:0] {
    QF_INT  = 2'd0,
    QF_HALF = 2'd1,
    QF_3Q   = 2'd2,
    QF_FULL = 2'd3
  } qfmt_e;

  localparam logic [7:0] A_CMD    = 8'h00;
  localparam logic [7:0] A_STAT   = 8'h01;
  localparam logic [7:0] A_CFG    = 8'h02;
  localparam logic [7:0] A_SAMPLE = 8'h03;
  localparam logic [7:0] A_RESULT = 8'h04;
  localparam logic [1:0] PG_COEF  = 2'b01;
  localparam logic [1:0] PG_DLY   = 2'b10;

  localparam int ST_BUSY = 0;
  localparam int ST_DONE = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_SAT  = 3;

  localparam int CF_TAPS_W = 7;
  localparam int CF_FMT_LO = 8;
  localparam int CF_IEN    = 12;
  localparam int CF_DEN    = 13;

  function automatic int unsigned q_shift(input qfmt_e f, input int unsigned dw);
    case (f)
      QF_INT:  q_shift = 0;
      QF_HALF: q_shift = dw / 2 - 1;
      QF_3Q:   q_shift = (3 * dw) / 4 - 1;
      default: q_shift = dw - 1;
    endcase
  endfunction

endpackage

// File: rtl/macflt_seq.sv
module macflt_seq
  import macflt_pkg::*;
#(
  parameter int MAX_TAPS = 64,
  localparam int IDX_W = $clog2(MAX_TAPS),
  localparam int CNT_W = $clog2(MAX_TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] taps,
  output logic             busy,
  output logic             clr_acc,
  output logic             mac_en,
  output logic             finish,
  output logic [IDX_W-1:0] tap_idx
);

  eng_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             last_tap;

  assign last_tap = (CNT_W'(idx_q) == (taps - CNT_W'(1)));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ENG_IDLE: begin
        if (start) state_d = ENG_PRIME;
      end
      ENG_PRIME: begin
        state_d = ENG_MAC;
        idx_d   = '0;
      end
      ENG_MAC: begin
        if (last_tap) state_d = ENG_FINISH;
        else          idx_d   = idx_q + IDX_W'(1);
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy    = (state_q != ENG_IDLE);
  assign clr_acc = (state_q == ENG_PRIME);
  assign mac_en  = (state_q == ENG_MAC);
  assign finish  = (state_q == ENG_FINISH);
  assign tap_idx = idx_q;

endmodule

// File: rtl/macflt_datapath.sv
module macflt_datapath
  import macflt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ACC_W    = 72,
  parameter int MAX_TAPS = 64,
  localparam int IDX_W  = $clog2(MAX_TAPS),
  localparam int PROD_W = 2 * DATA_W,
  localparam int EXT_W  = ACC_W - PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_we,
  input  logic              dly_we,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] coef_rd,
  output logic [DATA_W-1:0] dly_rd,
  input  logic              clr_acc,
  input  logic              mac_en,
  input  logic              finish,
  input  logic [IDX_W-1:0]  tap_idx,
  input  logic [DATA_W-1:0] sample,
  input  qfmt_e             fmt,
  output logic [DATA_W-1:0] result,
  output logic              sat
);

  logic [DATA_W-1:0] coef_mem [MAX_TAPS];
  logic [DATA_W-1:0] dly_mem  [MAX_TAPS];

  logic [DATA_W-1:0]        carry_q, carry_d;
  logic                     carry_en;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     acc_en;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  scaled;
  logic [ACC_W-DATA_W:0]    upper;
  logic                     ovf;
  logic [DATA_W-1:0]        result_q, result_d;
  logic                     sat_q;

  logic                     dw_en;
  logic [IDX_W-1:0]         dw_idx;
  logic [DATA_W-1:0]        dw_val;

  // Delay-line write port: the engine owns it during a run, the host otherwise.
  assign dw_en  = dly_we | mac_en;
  assign dw_idx = mac_en ? tap_idx : host_idx;
  assign dw_val = mac_en ? carry_q : host_wdata;

  always_ff @(posedge clk) begin
    if (coef_we) coef_mem[host_idx] <= host_wdata;
    if (dw_en)   dly_mem[dw_idx]    <= dw_val;
  end

  assign coef_rd = coef_mem[host_idx];
  assign dly_rd  = dly_mem[host_idx];

  // One product per cycle; the word carried forward is the sample entering this tap.
  assign prod = $signed(coef_mem[tap_idx]) * $signed(carry_q);

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    carry_en = clr_acc | mac_en;
    carry_d  = clr_acc ? sample : dly_mem[tap_idx];
    acc_en   = clr_acc | mac_en;
    acc_d    = clr_acc ? '0 : (acc_q + prod_ext);
  end

  // Scale and clip the finished sum.
  always_comb begin
    scaled = acc_q >>> q_shift(fmt, DATA_W);
    upper  = scaled[ACC_W-1:DATA_W-1];
    ovf    = !((&upper) || (~|upper));
    if (!ovf)
      result_d = scaled[DATA_W-1:0];
    else if (scaled[ACC_W-1])
      result_d = {1'b1, {(DATA_W-1){1'b0}}};
    else
      result_d = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= '0;
      acc_q    <= '0;
      result_q <= '0;
      sat_q    <= 1'b0;
    end else begin
      if (carry_en) carry_q <= carry_d;
      if (acc_en)   acc_q   <= acc_d;
      if (finish) begin
        result_q <= result_d;
        sat_q    <= ovf;
      end
    end
  end

  assign result = result_q;
  assign sat    = sat_q;

endmodule

// File: rtl/macflt_regif.sv
module macflt_regif
  import macflt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_TAPS = 64,
  localparam int IDX_W = $clog2(MAX_TAPS),
  localparam int CNT_W = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              busy,
  input  logic              finish,
  input  logic              sat,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] coef_rd,
  input  logic [DATA_W-1:0] dly_rd,
  output logic              start,
  output logic [CNT_W-1:0]  cfg_taps,
  output qfmt_e             cfg_fmt,
  output logic [DATA_W-1:0] sample,
  output logic              coef_we,
  output logic              dly_we,
  output logic [IDX_W-1:0]  mem_idx,
  output logic              irq,
  output logic              dma_req,
  output logic              done_flag,
  output logic              err_flag
);

  logic sel_cmd, sel_stat, sel_cfg, sel_smp, sel_res, sel_coef, sel_dly;
  logic in_range, fenced_wr;

  logic [CNT_W-1:0]  taps_q, taps_d;
  qfmt_e             fmt_q, fmt_d;
  logic              ien_q, ien_d, den_q, den_d;
  logic              cfg_en;
  logic [DATA_W-1:0] smp_q;
  logic              smp_en;
  logic              done_q, done_d, err_q, err_d;
  logic              dma_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] cfg_word, stat_word;
  logic [CF_TAPS_W-1:0] taps_in;

  assign in_range = (int'(host_addr[5:0]) < MAX_TAPS);
  assign sel_cmd  = (host_addr == A_CMD);
  assign sel_stat = (host_addr == A_STAT);
  assign sel_cfg  = (host_addr == A_CFG);
  assign sel_smp  = (host_addr == A_SAMPLE);
  assign sel_res  = (host_addr == A_RESULT);
  assign sel_coef = (host_addr[7:6] == PG_COEF) && in_range;
  assign sel_dly  = (host_addr[7:6] == PG_DLY) && in_range;

  assign fenced_wr = host_wr && busy && (sel_cfg || sel_smp || sel_coef || sel_dly);

  assign start   = host_wr && sel_cmd && host_wdata[0] && !busy;
  assign coef_we = host_wr && sel_coef && !busy;
  assign dly_we  = host_wr && sel_dly && !busy;
  assign mem_idx = host_addr[IDX_W-1:0];

  // Configuration write with tap-count clamping.
  assign taps_in = host_wdata[CF_TAPS_W-1:0];
  always_comb begin
    cfg_en = host_wr && sel_cfg && !busy;
    if (taps_in == '0)
      taps_d = CNT_W'(1);
    else if (int'(taps_in) > MAX_TAPS)
      taps_d = CNT_W'(MAX_TAPS);
    else
      taps_d = CNT_W'(taps_in);
    fmt_d = qfmt_e'(host_wdata[CF_FMT_LO+1:CF_FMT_LO]);
    ien_d = host_wdata[CF_IEN];
    den_d = host_wdata[CF_DEN];
    smp_en = host_wr && sel_smp && !busy;
  end

  // Sticky flags: a set event wins over a clear in the same cycle.
  always_comb begin
    done_d = done_q;
    if (start) done_d = 1'b0;
    else if (host_wr && sel_stat && host_wdata[ST_DONE]) done_d = 1'b0;
    if (finish) done_d = 1'b1;
    err_d = err_q;
    if (host_wr && sel_stat && host_wdata[ST_ERR]) err_d = 1'b0;
    if (fenced_wr) err_d = 1'b1;
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CF_TAPS_W-1:0]         = CF_TAPS_W'(taps_q);
    cfg_word[CF_FMT_LO+1:CF_FMT_LO] = fmt_q;
    cfg_word[CF_IEN]                = ien_q;
    cfg_word[CF_DEN]                = den_q;
    stat_word = '0;
    stat_word[ST_BUSY] = busy;
    stat_word[ST_DONE] = done_q;
    stat_word[ST_ERR]  = err_q;
    stat_word[ST_SAT]  = sat;
  end

  always_comb begin
    rdata_d = '0;
    if (sel_stat)                 rdata_d = stat_word;
    else if (busy)                rdata_d = '0;
    else if (sel_cfg)             rdata_d = cfg_word;
    else if (sel_smp)             rdata_d = smp_q;
    else if (sel_res)             rdata_d = result;
    else if (sel_coef)            rdata_d = coef_rd;
    else if (sel_dly)             rdata_d = dly_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taps_q  <= CNT_W'(1);
      fmt_q   <= QF_INT;
      ien_q   <= 1'b0;
      den_q   <= 1'b0;
      smp_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      dma_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cfg_en) begin
        taps_q <= taps_d;
        fmt_q  <= fmt_d;
        ien_q  <= ien_d;
        den_q  <= den_d;
      end
      if (smp_en)  smp_q   <= host_wdata;
      if (host_rd) rdata_q <= rdata_d;
      done_q <= done_d;
      err_q  <= err_d;
      dma_q  <= finish && den_q;
    end
  end

  assign host_rdata = rdata_q;
  assign cfg_taps   = taps_q;
  assign cfg_fmt    = fmt_q;
  assign sample     = smp_q;
  assign irq        = done_q && ien_q;
  assign dma_req    = dma_q;
  assign done_flag  = done_q;
  assign err_flag   = err_q;

endmodule

// File: rtl/macflt_core.sv
module macflt_core
  import macflt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ACC_W    = 72,
  parameter int MAX_TAPS = 64,
  localparam int IDX_W = $clog2(MAX_TAPS),
  localparam int CNT_W = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              dma_req
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              start, busy, clr_acc, mac_en, finish;
  logic [IDX_W-1:0]  tap_idx, mem_idx;
  logic [CNT_W-1:0]  cfg_taps;
  qfmt_e             cfg_fmt;
  logic [DATA_W-1:0] sample, result, coef_rd, dly_rd;
  logic              coef_we, dly_we, sat, done_flag, err_flag;

  macflt_regif #(.DATA_W(DATA_W), .MAX_TAPS(MAX_TAPS)) u_regif (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .finish     (finish),
    .sat        (sat),
    .result     (result),
    .coef_rd    (coef_rd),
    .dly_rd     (dly_rd),
    .start      (start),
    .cfg_taps   (cfg_taps),
    .cfg_fmt    (cfg_fmt),
    .sample     (sample),
    .coef_we    (coef_we),
    .dly_we     (dly_we),
    .mem_idx    (mem_idx),
    .irq        (irq),
    .dma_req    (dma_req),
    .done_flag  (done_flag),
    .err_flag   (err_flag)
  );

  macflt_seq #(.MAX_TAPS(MAX_TAPS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .taps    (cfg_taps),
    .busy    (busy),
    .clr_acc (clr_acc),
    .mac_en  (mac_en),
    .finish  (finish),
    .tap_idx (tap_idx)
  );

  macflt_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MAX_TAPS(MAX_TAPS)) u_dp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .coef_we    (coef_we),
    .dly_we     (dly_we),
    .host_idx   (mem_idx),
    .host_wdata (host_wdata),
    .coef_rd    (coef_rd),
    .dly_rd     (dly_rd),
    .clr_acc    (clr_acc),
    .mac_en     (mac_en),
    .finish     (finish),
    .tap_idx    (tap_idx),
    .sample     (sample),
    .fmt        (cfg_fmt),
    .result     (result),
    .sat        (sat)
  );

endmodule

// File: rtl/macflt_chk.sv
module macflt_chk
  import macflt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_TAPS = 64,
  localparam int CNT_W = $clog2(MAX_TAPS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              host_wr,
  input logic              host_rd,
  input logic [7:0]        host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              irq,
  input logic              dma_req,
  input logic              done_flag,
  input logic              err_flag,
  input logic [CNT_W-1:0]  cfg_taps
);

  logic guarded_w, guarded_r;
  logic [15:0] busy_cnt;

  assign guarded_w = (host_addr == A_CFG) || (host_addr == A_SAMPLE) ||
                     (host_addr[7:6] == PG_COEF) || (host_addr[7:6] == PG_DLY);
  assign guarded_r = guarded_w || (host_addr == A_RESULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 16'd1;
    else           busy_cnt <= '0;
  end

  // R2 / R8: every run lasts taps+2 cycles, a repeated start does not stretch it
  a_r2_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == (16'(cfg_taps) + 16'd2)));

  a_r2_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);

  a_r6_fenced_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && guarded_w) |=> err_flag);

  a_r7_fenced_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_rd && guarded_r) |=> (host_rdata == '0));

  a_r9_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy) || $past(host_wr)));

  a_r10_dma_single: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  a_r10_dma_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $fell(busy));

  a_r11_taps_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_taps >= CNT_W'(1)) && (int'(cfg_taps) <= MAX_TAPS));

endmodule

bind macflt_core macflt_chk #(.DATA_W(DATA_W), .MAX_TAPS(MAX_TAPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .busy       (busy),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .irq        (irq),
  .dma_req    (dma_req),
  .done_flag  (done_flag),
  .err_flag   (err_flag),
  .cfg_taps   (cfg_taps)
);

// File: tb/sim_macflt_core.sv
`timescale 1ns/1ps
module sim_macflt_core;

  logic        clk;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [7:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        irq, dma_req;

  macflt_core u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .dma_req(dma_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cyc = 0;
  int dma_cnt = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dma_req) dma_cnt <= dma_cnt + 1;
  end

  logic [31:0] m_coef [64];
  logic [31:0] m_dly  [64];

  // Vector: taps(7) fmt(2) sample(32) coefficient base(32)
  localparam int NV = 7;
  localparam logic [72:0] VEC [NV] = '{
    {7'd1,  2'd0, 32'd100,       32'd7},
    {7'd4,  2'd0, 32'hFFFF_FFFB, 32'd10},
    {7'd8,  2'd1, 32'd98304,     32'h0000_4000},
    {7'd64, 2'd3, 32'h4000_0000, 32'h1000_0000},
    {7'd16, 2'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF},
    {7'd1,  2'd0, 32'h8000_0000, 32'h7FFF_FFFF},
    {7'd5,  2'd2, 32'd12345678,  32'hFFED_CBAA}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [31:0] cfgw(input int n, input logic [1:0] f, input bit ien, input bit den);
    logic [31:0] w;
    w = '0;
    w[6:0] = 7'(n);
    w[9:8] = f;
    w[12]  = ien;
    w[13]  = den;
    return w;
  endfunction

  task automatic model_run(input int n, input logic [1:0] f, input logic [31:0] s,
                           output logic [31:0] r, output logic sat);
    logic signed [71:0] acc, sh;
    longint p;
    int amt;
    for (int i = n - 1; i > 0; i--) m_dly[i] = m_dly[i-1];
    m_dly[0] = s;
    acc = '0;
    for (int i = 0; i < n; i++) begin
      p = longint'($signed(m_coef[i])) * longint'($signed(m_dly[i]));
      acc = acc + {{8{p[63]}}, p};
    end
    amt = (f == 2'd0) ? 0 : (f == 2'd1) ? 15 : (f == 2'd2) ? 23 : 31;
    sh = acc >>> amt;
    if (sh > 72'sh0_7FFF_FFFF) begin
      r = 32'h7FFF_FFFF; sat = 1'b1;
    end else if (sh < -(72'sh0_8000_0000)) begin
      r = 32'h8000_0000; sat = 1'b1;
    end else begin
      r = sh[31:0]; sat = 1'b0;
    end
  endtask

  task automatic load_coefs(input logic [31:0] base);
    for (int i = 0; i < 64; i++) begin
      m_coef[i] = base - 32'(3 * i);
      hwr(8'(8'h40 + i), m_coef[i]);
    end
  endtask

  task automatic wait_end(input int start_cyc, output int len);
    int guard;
    guard = 0;
    while (!dma_req && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    len = cyc - start_cyc;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, er;
    logic es;
    int n, bad, t0, len;
    logic [1:0] f;

    host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 dma_req", {31'd0, dma_req}, 32'd0);
    hrd(8'h01, v); check("R1 status", v, 32'd0);
    hrd(8'h04, v); check("R1 result", v, 32'd0);
    hrd(8'h02, v); check("R1 R12 config", v, 32'h0000_0001);

    // R11 tap-count clamping
    hwr(8'h02, cfgw(0, 2'd0, 0, 0));
    hrd(8'h02, v); check("R11 clamp zero", v, 32'h0000_0001);
    hwr(8'h02, cfgw(100, 2'd2, 1, 0));
    hrd(8'h02, v); check("R11 clamp high", v, 32'h0000_1240);

    for (int i = 0; i < 64; i++) begin
      m_dly[i] = '0;
      hwr(8'(8'h80 + i), 32'd0);
    end

    // Vector table: R2 timing, R3 sum and shift, R4 formats, R5 clipping, R9/R10 signals
    for (int k = 0; k < NV; k++) begin
      n = int'(VEC[k][72:66]);
      f = VEC[k][65:64];
      hwr(8'h02, cfgw(n, f, 1, 1));
      hwr(8'h03, VEC[k][63:32]);
      load_coefs(VEC[k][31:0]);
      model_run(n, f, VEC[k][63:32], er, es);
      hwr(8'h00, 32'd1);
      bad = 0;
      for (int j = 1; j <= n + 1; j++) begin
        @(negedge clk);
        if (dma_req || irq) bad++;
      end
      check($sformatf("R2 no early end v%0d", k), 32'(bad), 32'd0);
      @(negedge clk);
      check($sformatf("R2 R10 dma at N+2 v%0d", k), {31'd0, dma_req}, 32'd1);
      check($sformatf("R9 irq at end v%0d", k), {31'd0, irq}, 32'd1);
      @(negedge clk);
      check($sformatf("R10 dma one cycle v%0d", k), {31'd0, dma_req}, 32'd0);
      hrd(8'h04, v);
      check($sformatf("R3 R4 R5 result v%0d", k), v, er);
      hrd(8'h01, v);
      check($sformatf("R5 R9 status v%0d", k), v, {28'd0, es, 1'b0, 1'b1, 1'b0});
    end

    // R3 delay line contents after the runs
    for (int i = 0; i < 6; i++) begin
      hrd(8'(8'h80 + i), v);
      check($sformatf("R3 delay word %0d", i), v, m_dly[i]);
    end

    // R6 R7 R8 host fenced out during a long run
    hwr(8'h02, cfgw(64, 2'd0, 1, 1));
    hwr(8'h03, 32'd3);
    model_run(64, 2'd0, 32'd3, er, es);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 8'h00; host_wdata = 32'd1;
    @(negedge clk);
    host_wr = 1'b0;
    t0 = cyc;
    hwr(8'h02, cfgw(2, 2'd1, 0, 0));
    hwr(8'h40, 32'h1234_5678);
    hwr(8'h85, 32'hDEAD_BEEF);
    hwr(8'h00, 32'd1);
    hrd(8'h02, v); check("R7 config reads zero", v, 32'd0);
    hrd(8'h40, v); check("R7 coef reads zero", v, 32'd0);
    hrd(8'h04, v); check("R7 result reads zero", v, 32'd0);
    hrd(8'h01, v); check("R6 R7 status while busy", v & 32'h7, 32'h5);
    wait_end(t0, len);
    check("R2 R8 run length 64 taps", 32'(len), 32'd66);
    hrd(8'h04, v); check("R6 R3 result unchanged by fenced writes", v, er);
    hrd(8'h02, v); check("R6 config kept", v, cfgw(64, 2'd0, 1, 1));
    hrd(8'h40, v); check("R6 coef kept", v, m_coef[0]);
    hrd(8'h85, v); check("R6 delay word kept", v, m_dly[5]);
    hwr(8'h01, 32'h4);
    hrd(8'h01, v); check("R6 error cleared, done kept", v & 32'h7, 32'h2);
    check("R9 irq while done", {31'd0, irq}, 32'd1);
    hwr(8'h01, 32'h2);
    @(negedge clk);
    check("R9 irq after done cleared", {31'd0, irq}, 32'd0);
    hrd(8'h01, v); check("R9 done cleared", v & 32'h2, 32'h0);

    // R9 R10 enables off
    hwr(8'h02, cfgw(2, 2'd0, 0, 0));
    hwr(8'h03, 32'd9);
    model_run(2, 2'd0, 32'd9, er, es);
    bad = dma_cnt;
    hwr(8'h00, 32'd1);
    repeat (10) @(negedge clk);
    check("R10 no dma when disabled", 32'(dma_cnt - bad), 32'd0);
    check("R9 no irq when disabled", {31'd0, irq}, 32'd0);
    hrd(8'h01, v); check("R9 done set without irq", v & 32'h3, 32'h2);
    hrd(8'h04, v); check("R3 two-tap result", v, er);

    finished = 1;
    summary();
    $finish;
  end

endmodule